// File: doc/BRIEF.md
# Indirect Byte-Wide Register Access Port

This block sits on the device side of an 8-bit parallel host bus. It exposes three host-visible ports, selected by a 2-bit port select. Through these ports the host reaches a 16-bit-addressed internal byte space. In this project that space is a small on-block memory used for test.

The host sets up an access in three steps. It loads the target address into the address port, low byte then high byte. It then writes a command byte that sets the direction and says whether the address advances. After that it moves any number of single bytes through the data port. Multi-byte values travel least significant byte first, with the advance enabled. With the advance cleared, every data-port access hits the same location, which suits a queue-like register.

Read data is offered combinationally. The byte at the current address appears on the read bus during the same cycle as the data-port read strobe, so even the first read after a command needs no wait cycle.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the internal address is 0x0000, the next address-port write loads the low half, and no command is latched, so a data-port read returns 0x00 until a command is written.
- R2: A write to port 0 loads the low address byte if the half toggle points low, and the high byte otherwise. It leaves the other half unchanged and flips the toggle.
- R3: A write to port 1 latches a command and returns the half toggle to low. Command bit 0 alone means read, bit 1 alone means write, and both or neither means idle. Bit 2 enables auto-advance. Bits 3 to 7 (access size, clear flag) have no effect.
- R4: While port 2 is selected and a read command is latched, the read bus shows the byte at the current address in the same cycle, including the first read after the command.
- R5: A port-2 write under a latched write command stores the byte at the current address.
- R6: With auto-advance set, each port-2 access in the latched direction increments the address by one. Bytes written in sequence therefore read back in the same order.
- R7: With auto-advance clear, port-2 accesses leave the address unchanged, and repeated reads return the byte at that one address.
- R8: A port-2 write while the latched command is not a write changes neither the memory nor the address.
- R9: The read bus is 0x00 whenever port 0 or port 1 is selected, and whenever port 2 is selected without a read command latched.
- R10: Auto-advance wraps the address from 0xFFFF to 0x0000.
- R11: The test memory decodes only the low MEM_AW address bits (8 by default), so address 0x1234 aliases 0x0034.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Port select: 0 address, 1 command, 2 data |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data to host, valid in the strobe cycle |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle, and that both strobes stay low while reset is held. The bench drives every access through a write task or a read task. Each task raises exactly one strobe for one clock, and the strobes are released before reset is applied. The bench also sends every address pair followed by a command, so each stream starts from a well-defined toggle state.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CMD_BIT_RD  = 0;
    localparam int CMD_BIT_WR  = 1;
    localparam int CMD_BIT_INC = 2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic inc;
    } hpb_cmd_t;
endpackage

// File: rtl/hpb_cmd_decode.sv
module hpb_cmd_decode
    import hpb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cmd_byte,
    output hpb_cmd_t          cmd
);
    always_comb begin
        cmd.rd  = cmd_byte[CMD_BIT_RD] & ~cmd_byte[CMD_BIT_WR];
        cmd.wr  = cmd_byte[CMD_BIT_WR] & ~cmd_byte[CMD_BIT_RD];
        cmd.inc = cmd_byte[CMD_BIT_INC];
    end
endmodule

// File: rtl/hpb_mem.sv
module hpb_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[addr] <= wdata;
        end
    end

    assign rdata = store_q[addr];
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int ADDR_W = 2 * DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hi_sel;
        hpb_cmd_t          cmd;
    } state_t;

    state_t            state_d, state_q;
    hpb_cmd_t          dec_cmd;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic              wr_addr, wr_cmd, wr_data, rd_data, step;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_hi_sel;
    logic              cur_rd, cur_wr, cur_inc;

    hpb_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .cmd_byte (host_wdata),
        .cmd      (dec_cmd)
    );

    hpb_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (state_q.addr[MEM_AW-1:0]),
        .wdata (host_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        state_d = state_q;
        wr_addr = host_wr && (host_sel == SEL_ADDR);
        wr_cmd  = host_wr && (host_sel == SEL_CMD);
        wr_data = host_wr && (host_sel == SEL_DATA);
        rd_data = host_rd && (host_sel == SEL_DATA);
        mem_we  = wr_data && state_q.cmd.wr;
        step    = mem_we || (rd_data && state_q.cmd.rd);

        if (wr_addr) begin
            if (state_q.hi_sel) begin
                state_d.addr[ADDR_W-1:DATA_W] = host_wdata;
            end else begin
                state_d.addr[DATA_W-1:0] = host_wdata;
            end
            state_d.hi_sel = ~state_q.hi_sel;
        end

        if (wr_cmd) begin
            state_d.cmd    = dec_cmd;
            state_d.hi_sel = 1'b0;
        end

        if (step && state_q.cmd.inc) begin
            state_d.addr = state_q.addr + 1'b1;
        end

        if ((host_sel == SEL_DATA) && state_q.cmd.rd) begin
            host_rdata = mem_rdata;
        end else begin
            host_rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_addr   = state_q.addr;
    assign cur_hi_sel = state_q.hi_sel;
    assign cur_rd     = state_q.cmd.rd;
    assign cur_wr     = state_q.cmd.wr;
    assign cur_inc    = state_q.cmd.inc;
endmodule

// File: rtl/hostport_bridge_chk.sv
module hostport_bridge_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          host_sel,
    input logic                host_wr,
    input logic                host_rd,
    input logic [DATA_W-1:0]   host_wdata,
    input logic [2*DATA_W-1:0] cur_addr,
    input logic                cur_hi_sel,
    input logic                cur_rd,
    input logic                cur_wr,
    input logic                cur_inc
);
    logic data_step;
    logic data_touch;
    assign data_touch = (host_sel == 2'd2) && (host_wr || host_rd);
    assign data_step  = (host_sel == 2'd2) && ((host_wr && cur_wr) || (host_rd && cur_rd));

    // Input assumption: the strobes are mutually exclusive.
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

    p_half_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0) |=> (cur_hi_sel != $past(cur_hi_sel)));

    p_low_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd0 && !cur_hi_sel) |=>
        (cur_addr[DATA_W-1:0] == $past(host_wdata)) &&
        (cur_addr[2*DATA_W-1:DATA_W] == $past(cur_addr[2*DATA_W-1:DATA_W])));

    p_cmd_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd1) |=> !cur_hi_sel);

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && cur_inc) |=> (cur_addr == $past(cur_addr) + 1'b1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_touch && !cur_inc) |=> $stable(cur_addr));

    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd2 && !cur_wr) |=> $stable(cur_addr));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && cur_inc && (&cur_addr)) |=> (cur_addr == '0));
endmodule

bind hostport_bridge hostport_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .cur_addr   (cur_addr),
    .cur_hi_sel (cur_hi_sel),
    .cur_rd     (cur_rd),
    .cur_wr     (cur_wr),
    .cur_inc    (cur_inc)
);

// File: tb/hostport_bridge_test.sv
module hostport_bridge_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hostport_bridge uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (sel),
        .host_wr    (wr),
        .host_rd    (rd),
        .host_wdata (wdata),
        .host_rdata (rdata)
    );

    // Entry: {sel[1:0], op[1:0] (0 write, 1 read and check), data[7:0], req[3:0]}
    localparam int NV = 30;
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'h10, 4'd6}, {2'd0, 2'd0, 8'h00, 4'd6},  // address 0x0010
        {2'd1, 2'd0, 8'h06, 4'd6},                              // write + advance
        {2'd2, 2'd0, 8'h11, 4'd5}, {2'd2, 2'd0, 8'h22, 4'd5},  // R5 stores
        {2'd2, 2'd0, 8'h33, 4'd5}, {2'd2, 2'd0, 8'h44, 4'd5},
        {2'd0, 2'd0, 8'h10, 4'd6}, {2'd0, 2'd0, 8'h00, 4'd6},
        {2'd1, 2'd0, 8'h05, 4'd6},                              // read + advance
        {2'd2, 2'd1, 8'h11, 4'd4},                              // R4 first read, no wait
        {2'd2, 2'd1, 8'h22, 4'd6}, {2'd2, 2'd1, 8'h33, 4'd6},  // R6 order
        {2'd2, 2'd1, 8'h44, 4'd6},
        {2'd0, 2'd0, 8'h11, 4'd7}, {2'd0, 2'd0, 8'h00, 4'd7},
        {2'd1, 2'd0, 8'h01, 4'd7},                              // read, fixed address
        {2'd2, 2'd1, 8'h22, 4'd7}, {2'd2, 2'd1, 8'h22, 4'd7},  // R7 repeated
        {2'd2, 2'd1, 8'h22, 4'd7},
        {2'd1, 2'd0, 8'hBD, 4'd3},                              // R3 size/clear bits set
        {2'd2, 2'd1, 8'h22, 4'd3}, {2'd2, 2'd1, 8'h33, 4'd3},
        {2'd1, 2'd0, 8'h03, 4'd3},                              // R3 both bits: idle
        {2'd2, 2'd1, 8'h00, 4'd3},
        {2'd1, 2'd0, 8'h02, 4'd5},                              // write, fixed at 0x0013
        {2'd2, 2'd0, 8'h99, 4'd5}, {2'd2, 2'd0, 8'hAA, 4'd5},
        {2'd1, 2'd0, 8'h01, 4'd5},
        {2'd2, 2'd1, 8'hAA, 4'd5}                               // R5 last write wins
    };

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, input logic [7:0] exp, input int req);
        @(negedge clk);
        sel = s; rd = 1'b1;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL R%0d: read port %0d got %h expected %h", req, s, rdata, exp);
        end
        @(posedge clk);
        #1 rd = 1'b0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [7:0] c);
        bus_wr(2'd0, a[7:0]);
        bus_wr(2'd0, a[15:8]);
        bus_wr(2'd1, c);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: no command after reset, data read gives zero
        bus_rd(2'd2, 8'h00, 1);
        // R1: address starts at 0x0000
        bus_wr(2'd1, 8'h06);
        bus_wr(2'd2, 8'h5A);
        setup(16'h0000, 8'h01);
        bus_rd(2'd2, 8'h5A, 1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][13:12] == 2'd0) begin
                bus_wr(VEC[i][15:14], VEC[i][11:4]);
            end else begin
                bus_rd(VEC[i][15:14], VEC[i][11:4], int'(VEC[i][3:0]));
            end
        end

        // R2: a command write rewinds the half toggle
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd1, 8'h06);
        bus_wr(2'd0, 8'h30);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'hC3);
        setup(16'h0030, 8'h01);
        bus_rd(2'd2, 8'hC3, 2);

        // R8: write under read command is ignored, address stays
        setup(16'h0030, 8'h05);
        bus_wr(2'd2, 8'hEE);
        bus_rd(2'd2, 8'hC3, 8);

        // R9: address and command ports read zero with a read latched
        setup(16'h0030, 8'h01);
        bus_rd(2'd0, 8'h00, 9);
        bus_rd(2'd1, 8'h00, 9);

        // R10: wrap from 0xFFFF to 0x0000
        setup(16'hFFFF, 8'h06);
        bus_wr(2'd2, 8'h5E);
        bus_wr(2'd2, 8'hE5);
        setup(16'h0000, 8'h01);
        bus_rd(2'd2, 8'hE5, 10);
        setup(16'hFFFF, 8'h05);
        bus_rd(2'd2, 8'h5E, 10);
        bus_rd(2'd2, 8'hE5, 10);

        // R11: upper address bits alias in the test memory
        setup(16'h1234, 8'h02);
        bus_wr(2'd2, 8'h9C);
        setup(16'h0034, 8'h01);
        bus_rd(2'd2, 8'h9C, 11);

        // R1: reset mid-run clears the latched command
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        bus_rd(2'd2, 8'h00, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule